// File: doc/BRIEF.md
# Test Access Port with User Scan Instructions

This block is a boundary-scan test access port controller built around the standard sixteen-state TAP machine. It holds a three-bit instruction register and one bypass bit. It decodes all eight instruction codes and picks the serial output source for each one. The possible sources are the bypass bit, the serial output of an external boundary register, a readback stream, a configuration output stream, or one of two user-logic serial returns.

Two of the instructions hand the data-register phase to on-chip logic. While one of them is current, its select strobe is high. A gated data-register clock then pulses on every TCK rising edge that captures or shifts. The user logic also sees TDI directly and an idle flag, so it can build private scan chains without touching the controller. A two-bit field tells the pad logic what should drive the I/O pins under the current instruction.

Top module: `jtag_user_tap`

## Requirements
- R1: Holding `trst_n` low at a rising TCK edge puts the TAP in Test-Logic-Reset. From any state, TMS high on five consecutive rising edges also reaches Test-Logic-Reset. In that state the instruction becomes 3'b111 (bypass) at the falling edge, and both select strobes drop.
- R2: In Shift-DR, TDO comes from a source chosen by the instruction. Codes 3'b000 and 3'b001 select `bsr_so`. 3'b010 selects `user_tdo1` and 3'b011 selects `user_tdo2`. 3'b100 selects `rb_data` and 3'b101 selects `cfg_dout`. 3'b110 and 3'b111 select the bypass bit.
- R3: The bypass bit loads 0 in Capture-DR and takes TDI on each Shift-DR rising edge. The first bit shifted out is therefore 0, and each TDI bit appears on TDO one shift later. Pause-DR keeps the bit.
- R4: `user_sel1` is high exactly while the instruction is 3'b010, and `user_sel2` exactly while it is 3'b011.
- R5: `user_idle` is high exactly while the TAP is in Run-Test/Idle.
- R6: TDO and `tdo_oe` update on the falling TCK edge. `tdo_oe` is high only in Shift-IR and Shift-DR.
- R7: Capture-IR loads 3'b001 into the instruction shifter. The shifter moves out LSB first, with TDI entering at the MSB. The new instruction takes effect at the falling edge in Update-IR, and not before.
- R8: Under a user instruction, `user_drck` gives one pulse on the edge leaving Capture-DR and one on each Shift-DR rising edge. Under any other instruction it stays low.
- R9: `io_src` is 2'b11 for 3'b000 (boundary register drives the pins) and 2'b01 for the user codes. It is 2'b10 (pins disabled) for 3'b101, and 2'b00 (pins driven by logic) for all other codes.
- R10: `user_tdi` follows `tdi` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | High while TDO is driven |
| bsr_so | input | 1 | Serial output of the external boundary register |
| rb_data | input | 1 | Readback serial stream |
| cfg_dout | input | 1 | Configuration serial output stream |
| user_tdo1 | input | 1 | Serial return of user chain 1 |
| user_tdo2 | input | 1 | Serial return of user chain 2 |
| user_tdi | output | 1 | TDI passed to user logic |
| user_sel1 | output | 1 | User instruction 1 is current |
| user_sel2 | output | 1 | User instruction 2 is current |
| user_idle | output | 1 | TAP is in Run-Test/Idle |
| user_drck | output | 1 | Gated data-register clock for user logic |
| io_src | output | 2 | Pin data source field |

## Verification
The assertions assume that TMS and TDI change only while TCK is low, and that `trst_n` is sampled on both edges like any other synchronous input. The bench keeps to this by changing every input one nanosecond after a falling edge. It samples the outputs there too, once the falling-edge registers have settled. The source inputs are held constant across each scan, so that each TDO value can be traced to exactly one source. The eight codes are swept twice, once with the selected source at 1 and all others at 0, and once with the levels inverted.

// File: rtl/jtag_user_pkg.sv
// Shared types for the user-scan TAP: state encoding and instruction codes.
// Assumes a fixed three-bit instruction register.
package jtag_user_pkg;
    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_TLR    = 4'd0,  ST_RTI    = 4'd1,
        ST_SELDR  = 4'd2,  ST_CAPDR  = 4'd3,
        ST_SHDR   = 4'd4,  ST_EX1DR  = 4'd5,
        ST_PAUDR  = 4'd6,  ST_EX2DR  = 4'd7,
        ST_UPDDR  = 4'd8,  ST_SELIR  = 4'd9,
        ST_CAPIR  = 4'd10, ST_SHIR   = 4'd11,
        ST_EX1IR  = 4'd12, ST_PAUIR  = 4'd13,
        ST_EX2IR  = 4'd14, ST_UPDIR  = 4'd15
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
    localparam logic [IR_W-1:0] OP_USER1   = 3'b010;
    localparam logic [IR_W-1:0] OP_USER2   = 3'b011;
    localparam logic [IR_W-1:0] OP_RDBK    = 3'b100;
    localparam logic [IR_W-1:0] OP_CONFIG  = 3'b101;
    localparam logic [IR_W-1:0] OP_RSVD    = 3'b110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    // Pin data source field values
    localparam logic [1:0] IO_LOGIC = 2'b00;
    localparam logic [1:0] IO_USER  = 2'b01;
    localparam logic [1:0] IO_OFF   = 2'b10;
    localparam logic [1:0] IO_BSR   = 2'b11;
endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state TAP controller advanced on the rising TCK edge.
// Assumes TMS is stable around the rising edge; trst_n is synchronous.
module jtag_tap_fsm
    import jtag_user_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;

    // Next-state decode of the TMS-driven walk
    always_comb begin
        unique case (state)
            ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
            ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
            ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: nxt = tms ? ST_UPDDR : ST_PAUDR;
            ST_PAUDR: nxt = tms ? ST_EX2DR : ST_PAUDR;
            ST_EX2DR: nxt = tms ? ST_UPDDR : ST_SHDR;
            ST_UPDDR: nxt = tms ? ST_SELDR : ST_RTI;
            ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
            ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: nxt = tms ? ST_UPDIR : ST_PAUIR;
            ST_PAUIR: nxt = tms ? ST_EX2IR : ST_PAUIR;
            ST_EX2IR: nxt = tms ? ST_UPDIR : ST_SHIR;
            ST_UPDIR: nxt = tms ? ST_SELDR : ST_RTI;
            default:  nxt = ST_TLR;
        endcase
    end

    // State register with synchronous test reset
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // R1: five TMS-high edges always land in Test-Logic-Reset
    a_r1_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == ST_TLR);

    // R1: TMS high in Test-Logic-Reset keeps it there
    a_r1_hold_tlr: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && tms) |=> state == ST_TLR);
endmodule

// File: rtl/jtag_ir_unit.sv
// Instruction shifter (rising edge) and instruction register (falling edge)
// with decode of select strobes and the pin source field.
// Assumes the state input comes from the TAP controller on the same TCK.
module jtag_ir_unit
    import jtag_user_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_lsb,
    output logic            sel1,
    output logic            sel2,
    output logic [1:0]      io_src
);
    logic [IR_W-1:0] ir_sr;

    // Capture the fixed pattern, then shift LSB-first with TDI at the MSB
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= IR_CAPTURE;
        else if (state == ST_CAPIR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SHIR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Instruction register: bypass on reset, new code at Update-IR
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_TLR) ir <= OP_BYPASS;
        else if (state == ST_UPDIR)     ir <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];
    assign sel1   = (ir == OP_USER1);
    assign sel2   = (ir == OP_USER2);

    // Pin data source decode
    always_comb begin
        unique case (ir)
            OP_EXTEST:          io_src = IO_BSR;
            OP_USER1, OP_USER2: io_src = IO_USER;
            OP_CONFIG:          io_src = IO_OFF;
            default:            io_src = IO_LOGIC;
        endcase
    end

    // R7: Capture-IR leaves the shifter holding 001
    a_r7_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAPIR |=> ir_sr == IR_CAPTURE);

    // R7: the instruction is stable across a rising edge outside reset
    a_r7_ir_stable: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPDIR && state != ST_TLR && $past(state) != ST_UPDIR
         && $past(state) != ST_TLR && $past(trst_n)) |-> $stable(ir));

    // R4: the two select strobes never overlap
    a_r4_sel_excl: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({sel1, sel2}));
endmodule

// File: rtl/jtag_dr_path.sv
// Bypass bit, falling-edge TDO mux with output enable, and the gated
// data-register clock for user chains. Assumes glitch-free TCK.
module jtag_dr_path
    import jtag_user_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  logic [IR_W-1:0] ir,
    input  logic            ir_lsb,
    input  logic            tdi,
    input  logic            bsr_so,
    input  logic            rb_data,
    input  logic            cfg_dout,
    input  logic            user_tdo1,
    input  logic            user_tdo2,
    output logic            tdo,
    output logic            tdo_oe,
    output logic            drck
);
    logic bypass_q;
    logic dr_bit;
    logic drck_en;
    logic user_op;

    assign user_op = (ir == OP_USER1) || (ir == OP_USER2);

    // Bypass bit: zero on capture, TDI on shift
    always_ff @(posedge tck) begin
        if (!trst_n)                bypass_q <= 1'b0;
        else if (state == ST_CAPDR) bypass_q <= 1'b0;
        else if (state == ST_SHDR)  bypass_q <= tdi;
    end

    // Data-register source selection by instruction
    always_comb begin
        unique case (ir)
            OP_EXTEST, OP_SAMPLE: dr_bit = bsr_so;
            OP_USER1:             dr_bit = user_tdo1;
            OP_USER2:             dr_bit = user_tdo2;
            OP_RDBK:              dr_bit = rb_data;
            OP_CONFIG:            dr_bit = cfg_dout;
            default:              dr_bit = bypass_q;
        endcase
    end

    // Falling-edge TDO and enable, driven only in the shift states
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SHIR) || (state == ST_SHDR);
            tdo    <= (state == ST_SHIR) ? ir_lsb :
                      (state == ST_SHDR) ? dr_bit : 1'b0;
        end
    end

    // Clock enable latched on the falling edge so the gated clock is whole
    always_ff @(negedge tck) begin
        if (!trst_n) drck_en <= 1'b0;
        else         drck_en <= user_op && (state == ST_CAPDR || state == ST_SHDR);
    end

    assign drck = tck & drck_en;

    // R6: output enable at the rising edge matches a shift state
    a_r6_oe_shift: assert property (@(posedge tck) disable iff (!trst_n)
        $past(trst_n) |-> tdo_oe == (state == ST_SHIR || state == ST_SHDR));

    // R8: the DR clock is enabled only under a user instruction in capture/shift
    a_r8_drck_gate: assert property (@(posedge tck) disable iff (!trst_n)
        drck_en |-> (user_op && (state == ST_CAPDR || state == ST_SHDR)));

    // R3: Capture-DR clears the bypass bit
    a_r3_bypass_capture: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAPDR |=> bypass_q == 1'b0);
endmodule

// File: rtl/jtag_user_tap.sv
// Top of the user-scan test access port: ties the TAP controller, the
// instruction unit and the data path together and exports the user side.
// Assumes TMS/TDI change while TCK is low.
module jtag_user_tap
    import jtag_user_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic       tdo_oe,
    input  logic       bsr_so,
    input  logic       rb_data,
    input  logic       cfg_dout,
    input  logic       user_tdo1,
    input  logic       user_tdo2,
    output logic       user_tdi,
    output logic       user_sel1,
    output logic       user_sel2,
    output logic       user_idle,
    output logic       user_drck,
    output logic [1:0] io_src
);
    tap_state_t      state;
    logic [IR_W-1:0] ir;
    logic            ir_lsb;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jtag_ir_unit u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir     (ir),
        .ir_lsb (ir_lsb),
        .sel1   (user_sel1),
        .sel2   (user_sel2),
        .io_src (io_src)
    );

    jtag_dr_path u_dr (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .ir        (ir),
        .ir_lsb    (ir_lsb),
        .tdi       (tdi),
        .bsr_so    (bsr_so),
        .rb_data   (rb_data),
        .cfg_dout  (cfg_dout),
        .user_tdo1 (user_tdo1),
        .user_tdo2 (user_tdo2),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .drck      (user_drck)
    );

    assign user_tdi  = tdi;
    assign user_idle = (state == ST_RTI);

    // R5: idle flag tracks Run-Test/Idle entry from a TMS-low edge
    a_r5_idle: assert property (@(posedge tck) disable iff (!trst_n)
        (user_idle && !tms) |=> user_idle);
endmodule

// File: tb/jtag_user_tap_bench.sv
// Self-checking bench: sweeps all instruction codes with both source polarities.
module jtag_user_tap_bench;
    logic tck = 1'b0;
    logic trst_n, tms, tdi;
    logic bsr_so, rb_data, cfg_dout, user_tdo1, user_tdo2;
    logic tdo, tdo_oe, user_tdi, user_sel1, user_sel2, user_idle, user_drck;
    logic [1:0] io_src;
    int n_run = 0;
    int n_fail = 0;
    int drck_cnt = 0;
    bit done = 0;

    always #10 tck = ~tck;

    jtag_user_tap u_jtag_user_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .bsr_so(bsr_so), .rb_data(rb_data), .cfg_dout(cfg_dout),
        .user_tdo1(user_tdo1), .user_tdo2(user_tdo2), .user_tdi(user_tdi),
        .user_sel1(user_sel1), .user_sel2(user_sel2), .user_idle(user_idle),
        .user_drck(user_drck), .io_src(io_src)
    );

    always @(posedge user_drck) drck_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    // Expected source index: 0 bsr, 1 tdo1, 2 tdo2, 3 rb, 4 cfg, 5 bypass
    function automatic int src_of(input int code);
        case (code)
            0, 1: return 0;
            2: return 1;
            3: return 2;
            4: return 3;
            5: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int io_of(input int code);
        if (code == 0) return 3;
        if (code == 2 || code == 3) return 1;
        if (code == 5) return 2;
        return 0;
    endfunction

    task automatic set_srcs(input int sel, input logic lvl);
        bsr_so    = (sel == 0) ? lvl : ~lvl;
        user_tdo1 = (sel == 1) ? lvl : ~lvl;
        user_tdo2 = (sel == 2) ? lvl : ~lvl;
        rb_data   = (sel == 3) ? lvl : ~lvl;
        cfg_dout  = (sel == 4) ? lvl : ~lvl;
    endtask

    // Load an instruction from Run-Test/Idle, checking capture and update timing
    task automatic load_ir(input int code);
        logic prev1;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R7 capture bit0", tdo, 1);
        chk("R6 oe in Shift-IR", tdo_oe, 1);
        prev1 = user_sel1;
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            if (i == 0) chk("R7 capture bit1", tdo, 0);
            if (i == 1) chk("R7 capture bit2", tdo, 0);
        end
        chk("R6 oe low in Exit1-IR", tdo_oe, 0);
        chk("R7 no early update", user_sel1, prev1);
        tick(1, 0);
        chk("R4 sel1 at Update-IR", user_sel1, code == 2);
        chk("R4 sel2 at Update-IR", user_sel2, code == 3);
        tick(0, 0);
        chk("R5 idle in RTI", user_idle, 1);
    endtask

    initial begin
        trst_n = 0; tms = 1; tdi = 0;
        set_srcs(0, 0);
        tick(1, 0); tick(1, 0);
        chk("R1 reset sel1", user_sel1, 0);
        chk("R1 reset io_src bypass", io_src, 0);
        chk("R6 reset oe", tdo_oe, 0);
        trst_n = 1;
        tick(1, 0);
        chk("R5 idle low in TLR", user_idle, 0);
        tick(0, 0);
        chk("R5 idle in RTI", user_idle, 1);
        tdi = 1; #1 chk("R10 tdi passthrough hi", user_tdi, 1);
        tdi = 0; #1 chk("R10 tdi passthrough lo", user_tdi, 0);

        for (int code = 0; code < 8; code++) begin
            load_ir(code);
            chk("R9 io_src", io_src, io_of(code));
            chk("R4 sel1", user_sel1, code == 2);
            chk("R4 sel2", user_sel2, code == 3);
            for (int pol = 0; pol < 2; pol++) begin
                logic lvl;
                logic [3:0] din;
                lvl = (pol == 0);
                din = (pol == 0) ? 4'b1011 : 4'b0100;
                set_srcs(src_of(code), lvl);
                if (src_of(code) == 5) set_srcs(-1, 1'b0);
                drck_cnt = 0;
                tick(1, 0); tick(0, 0);
                chk("R5 idle low in Capture-DR", user_idle, 0);
                tick(0, 0);
                chk("R6 oe in Shift-DR", tdo_oe, 1);
                if (src_of(code) == 5) chk("R3 bypass first bit", tdo, 0);
                else chk("R2 source bit", tdo, lvl);
                for (int i = 0; i < 4; i++) begin
                    tick(i == 3, din[i]);
                    if (i < 3) begin
                        if (src_of(code) == 5) chk("R3 bypass delay", tdo, din[i]);
                        else chk("R2 source held", tdo, lvl);
                    end
                end
                chk("R6 oe low in Exit1-DR", tdo_oe, 0);
                tick(1, 0); tick(0, 0);
                chk("R8 drck pulses", drck_cnt, (code == 2 || code == 3) ? 5 : 0);
            end
        end

        // Pause path under bypass keeps the shifted bit (R3)
        load_ir(7);
        set_srcs(-1, 1'b0);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R3 pause first bit", tdo, 0);
        tick(1, 1);
        tick(0, 0);
        chk("R6 oe low in Pause-DR", tdo_oe, 0);
        tick(1, 0); tick(0, 0);
        chk("R3 bit kept over pause", tdo, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R1: five TMS-high edges from Shift-DR under USER1
        load_ir(2);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk("R1 tms reset sel1", user_sel1, 0);
        chk("R1 tms reset io_src", io_src, 0);
        chk("R1 tms reset idle", user_idle, 0);
        tick(0, 0);
        chk("R1 tms reset then idle", user_idle, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule